// File: doc/BRIEF.md
# Branch Condition and Link Evaluator

This is a purely combinational unit for a 32-bit core with one branch delay slot. It decides whether a conditional branch is taken and computes where it goes. It is given four things:

- the 6-bit primary opcode and the 5-bit secondary selector taken from the instruction;
- the two source register values;
- the address of the branch instruction;
- the 16-bit word offset.

It returns five results:

- a taken flag;
- the branch target;
- a request to write the return address into the link register;
- the number of that register and the return address;
- a flag telling the pipeline to squash the delay-slot instruction.

Two families are covered. The first is the compare-with-zero group selected by the selector field under primary opcode 0x01. It has plain, linking and "likely" variants. The second is the primary-opcode compare branches and their likely twins.

A likely branch that is not taken discards its delay slot. A linking branch always writes the return address, whatever the outcome. Any encoding outside these two families drives every flag low, so the surrounding decoder may present any instruction word without qualification.

Top module: `branch_resolver`

## Requirements
- R1: With opcode 0x01, selector 0x00 takes the branch when rs is negative (signed), and selector 0x01 takes it when rs is zero or positive.
- R2: With opcode 0x01, selectors 0x02 and 0x03 test the same conditions as 0x00 and 0x01. When their condition is false they assert nullify; when it is true they assert taken.
- R3: With opcode 0x01, selectors 0x10/0x11 (and 0x12/0x13, likely) test less-than-zero and greater-or-equal-zero. These forms assert link_we whether or not the branch is taken, with link_reg = 31 and link_addr = pc + 8.
- R4: Opcode 0x04 is taken when rs equals rt, and opcode 0x05 is taken when they differ.
- R5: Opcode 0x06 is taken when rs <= 0 (signed), and opcode 0x07 is taken when rs > 0. rt has no effect on either.
- R6: Opcodes 0x14..0x17 use the conditions of 0x04..0x07 and assert nullify when not taken.
- R7: target = pc + 4 + (sign-extended offset << 2), wrapping modulo 2^32.
- R8: nullify and taken are never both high, and nullify is only ever high for a likely form. Non-linking forms never assert link_we.
- R9: Any other opcode, and any opcode-0x01 selector not listed above, gives taken = 0, link_we = 0 and nullify = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opcode | input | 6 | Primary opcode field |
| sel | input | 5 | Secondary selector (rt field) |
| rs_val | input | 32 | First source register value |
| rt_val | input | 32 | Second source register value |
| pc | input | 32 | Address of the branch instruction |
| offset | input | 16 | Signed word offset |
| taken | output | 1 | Branch condition met on a recognised branch |
| target | output | 32 | Branch destination address |
| link_we | output | 1 | Request to write the return address |
| link_reg | output | 5 | Destination register of the link write |
| link_addr | output | 32 | Return address, pc + 8 |
| nullify | output | 1 | Squash the delay slot (likely form, not taken) |

## Verification
The hardest cases to reach are the value boundaries of the signed compares. Examples are rs at 0, at -1, at the most negative value and at the most positive value. In each, one bit decides between the less-than and greater-or-equal outcomes, and between taken and nullify for the likely forms.

The stimulus walks every listed encoding through these boundary values. It also sweeps the rest of the opcode-0x01 selector space and a set of unrelated opcodes, to show that no flag leaks. Target arithmetic is driven with offsets of 0x7FFF and 0x8000 and with a PC near the top of the address space, so that sign extension and wrap-around are both exercised.

// File: rtl/branch_resolver.sv
module branch_resolver #(
  parameter int XLEN       = 32,
  parameter int OPW        = 6,
  parameter int SELW       = 5,
  parameter int OFFW       = 16,
  parameter int REGW       = 5,
  parameter int LINK_REG   = 31,
  parameter int INSN_BYTES = 4
) (
  input  logic [OPW-1:0]  opcode,
  input  logic [SELW-1:0] sel,
  input  logic [XLEN-1:0] rs_val,
  input  logic [XLEN-1:0] rt_val,
  input  logic [XLEN-1:0] pc,
  input  logic [OFFW-1:0] offset,
  output logic            taken,
  output logic [XLEN-1:0] target,
  output logic            link_we,
  output logic [REGW-1:0] link_reg,
  output logic [XLEN-1:0] link_addr,
  output logic            nullify
);
  localparam int SHW = XLEN - OFFW - 2;
  localparam logic [OPW-1:0] OP_ZGRP = OPW'(1);

  logic rs_neg, rs_zero, rs_eq;
  logic valid, likely, link, cond;

  assign rs_neg  = rs_val[XLEN-1];
  assign rs_zero = (rs_val == '0);
  assign rs_eq   = (rs_val == rt_val);

  always_comb begin
    valid  = 1'b0;
    likely = 1'b0;
    link   = 1'b0;
    cond   = 1'b0;
    if (opcode == OP_ZGRP) begin
      valid  = (sel[3:2] == 2'b00);
      link   = sel[4];
      likely = sel[1];
      cond   = sel[0] ? !rs_neg : rs_neg;
    end else if (opcode[OPW-1:3] == '0 || opcode[OPW-1:3] == (OPW-3)'(2)) begin
      valid  = opcode[2];
      likely = opcode[4];
      case (opcode[1:0])
        2'd0: cond = rs_eq;
        2'd1: cond = !rs_eq;
        2'd2: cond = rs_neg || rs_zero;
        default: cond = !rs_neg && !rs_zero;
      endcase
    end
  end

  assign taken     = valid && cond;
  assign nullify   = valid && likely && !cond;
  assign link_we   = valid && link;
  assign link_reg  = REGW'(LINK_REG);
  assign link_addr = pc + XLEN'(2 * INSN_BYTES);
  assign target    = pc + XLEN'(INSN_BYTES) + {{SHW{offset[OFFW-1]}}, offset, 2'b00};
endmodule

// File: rtl/branch_resolver_chk.sv
module branch_resolver_chk #(
  parameter int XLEN = 32,
  parameter int OPW  = 6,
  parameter int SELW = 5,
  parameter int OFFW = 16,
  parameter int REGW = 5
) (
  input logic [OPW-1:0]  opcode,
  input logic [SELW-1:0] sel,
  input logic [XLEN-1:0] rs_val,
  input logic [XLEN-1:0] pc,
  input logic [OFFW-1:0] offset,
  input logic            taken,
  input logic [XLEN-1:0] target,
  input logic            link_we,
  input logic [REGW-1:0] link_reg,
  input logic [XLEN-1:0] link_addr,
  input logic            nullify
);
  logic known_op;
  assign known_op = (opcode == 6'h01) || (opcode >= 6'h04 && opcode <= 6'h07) ||
                    (opcode >= 6'h14 && opcode <= 6'h17);

  always_comb begin
    assert_no_taken_and_nullify_R8: assert (!(taken && nullify))
      else $error("taken and nullify both high");
    assert_nullify_likely_only_R8: assert (!nullify || opcode[4] || (opcode == 6'h01 && sel[1]))
      else $error("nullify on non-likely form");
    assert_link_regimm_only_R3: assert (!link_we || (opcode == 6'h01 && sel[4]))
      else $error("link outside linking forms");
    assert_link_values_R3: assert (!link_we || (link_reg == 5'd31 && link_addr - pc == 32'd8))
      else $error("bad link destination");
    assert_unknown_quiet_R9: assert (known_op || (!taken && !link_we && !nullify))
      else $error("flag on unknown opcode");
    assert_zero_offset_target_R7: assert (offset != '0 || target - pc == 32'd4)
      else $error("zero offset target wrong");
    assert_blez_zero_R5: assert (!(opcode == 6'h06 && rs_val == '0) || taken)
      else $error("le-zero not taken at zero");
  end
endmodule

bind branch_resolver branch_resolver_chk #(
  .XLEN(XLEN), .OPW(OPW), .SELW(SELW), .OFFW(OFFW), .REGW(REGW)
) i_branch_resolver_chk (
  .opcode(opcode), .sel(sel), .rs_val(rs_val), .pc(pc), .offset(offset),
  .taken(taken), .target(target), .link_we(link_we), .link_reg(link_reg),
  .link_addr(link_addr), .nullify(nullify)
);

// File: tb/test_branch_resolver.sv
module test_branch_resolver;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [5:0]  opcode;
  logic [4:0]  sel;
  logic [31:0] rs_val, rt_val, pc;
  logic [15:0] offset;
  logic        taken, link_we, nullify;
  logic [31:0] target, link_addr;
  logic [4:0]  link_reg;

  branch_resolver i_branch_resolver (
    .opcode(opcode), .sel(sel), .rs_val(rs_val), .rt_val(rt_val), .pc(pc),
    .offset(offset), .taken(taken), .target(target), .link_we(link_we),
    .link_reg(link_reg), .link_addr(link_addr), .nullify(nullify)
  );

  typedef struct {
    logic        taken;
    logic [31:0] target;
    logic        link_we;
    logic [31:0] link_addr;
    logic        nullify;
    string       tag;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  function automatic exp_t model(input logic [5:0] op, input logic [4:0] s,
                                 input logic [31:0] a, input logic [31:0] b,
                                 input logic [31:0] p, input logic [15:0] off,
                                 input string tag);
    exp_t e;
    bit hit, c, lk, ln;
    hit = 0; c = 0; lk = 0; ln = 0;
    if (op == 6'h01) begin
      case (s)
        5'h00: begin hit = 1; c = $signed(a) < 0; end
        5'h01: begin hit = 1; c = $signed(a) >= 0; end
        5'h02: begin hit = 1; lk = 1; c = $signed(a) < 0; end
        5'h03: begin hit = 1; lk = 1; c = $signed(a) >= 0; end
        5'h10: begin hit = 1; ln = 1; c = $signed(a) < 0; end
        5'h11: begin hit = 1; ln = 1; c = $signed(a) >= 0; end
        5'h12: begin hit = 1; ln = 1; lk = 1; c = $signed(a) < 0; end
        5'h13: begin hit = 1; ln = 1; lk = 1; c = $signed(a) >= 0; end
        default: hit = 0;
      endcase
    end else if ((op >= 6'h04 && op <= 6'h07) || (op >= 6'h14 && op <= 6'h17)) begin
      hit = 1;
      lk = (op >= 6'h14);
      case (op & 6'h0F)
        6'h04: c = (a == b);
        6'h05: c = (a != b);
        6'h06: c = $signed(a) <= 0;
        default: c = $signed(a) > 0;
      endcase
    end
    e.taken     = hit && c;
    e.nullify   = hit && lk && !c;
    e.link_we   = hit && ln;
    e.link_addr = p + 32'd8;
    e.target    = p + 32'd4 + 32'($signed(off)) * 4;
    e.tag       = tag;
    return e;
  endfunction

  task automatic drive(input logic [5:0] op, input logic [4:0] s, input logic [31:0] a,
                       input logic [31:0] b, input logic [31:0] p, input logic [15:0] off,
                       input string tag);
    @(negedge clk);
    opcode = op; sel = s; rs_val = a; rt_val = b; pc = p; offset = off;
    q.push_back(model(op, s, a, b, p, off, tag));
  endtask

  always @(posedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (taken !== e.taken || target !== e.target || link_we !== e.link_we ||
          nullify !== e.nullify || (e.link_we && (link_addr !== e.link_addr || link_reg !== 5'd31))) begin
        failures++;
        $display("FAIL %s: got t=%0b tgt=%h lw=%0b la=%h lr=%0d n=%0b exp t=%0b tgt=%h lw=%0b la=%h n=%0b",
                 e.tag, taken, target, link_we, link_addr, link_reg, nullify,
                 e.taken, e.target, e.link_we, e.link_addr, e.nullify);
      end
    end
  end

  initial begin
    opcode = '0; sel = '0; rs_val = '0; rt_val = '0; pc = '0; offset = '0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    drive(6'h00, 5'h00, 32'h0, 32'h0, 32'h0, 16'h0, "R9 idle");
    begin
      logic [31:0] vals [5];
      vals = '{32'h0, 32'hFFFF_FFFF, 32'h8000_0000, 32'h7FFF_FFFF, 32'h1};
      for (int i = 0; i < 5; i++) begin
        drive(6'h01, 5'h00, vals[i], 32'h5, 32'h1000, 16'h10, "R1 lt");
        drive(6'h01, 5'h01, vals[i], 32'h5, 32'h1000, 16'h10, "R1 ge");
        drive(6'h01, 5'h02, vals[i], 32'h5, 32'h1000, 16'h10, "R2 lt likely");
        drive(6'h01, 5'h03, vals[i], 32'h5, 32'h1000, 16'h10, "R2 ge likely");
        drive(6'h01, 5'h10, vals[i], 32'h0, 32'h2000, 16'hFFFF, "R3 lt link");
        drive(6'h01, 5'h11, vals[i], 32'h0, 32'h2000, 16'hFFFF, "R3 ge link");
        drive(6'h01, 5'h12, vals[i], 32'h0, 32'h2000, 16'h4, "R3 lt link likely");
        drive(6'h01, 5'h13, vals[i], 32'h0, 32'h2000, 16'h4, "R3 ge link likely");
        drive(6'h06, 5'h00, vals[i], 32'h9, 32'h3000, 16'h1, "R5 le");
        drive(6'h07, 5'h00, vals[i], 32'hFFFF_FFFF, 32'h3000, 16'h1, "R5 gt");
        drive(6'h16, 5'h00, vals[i], 32'h0, 32'h3000, 16'h1, "R6 le likely");
        drive(6'h17, 5'h00, vals[i], 32'h0, 32'h3000, 16'h1, "R6 gt likely");
      end
    end
    drive(6'h04, 5'h00, 32'h1234, 32'h1234, 32'h400, 16'h8, "R4 eq equal");
    drive(6'h04, 5'h00, 32'h1234, 32'h1235, 32'h400, 16'h8, "R4 eq differ");
    drive(6'h05, 5'h00, 32'h1234, 32'h1234, 32'h400, 16'h8, "R4 ne equal");
    drive(6'h05, 5'h00, 32'h8000_0000, 32'h0, 32'h400, 16'h8, "R4 ne differ");
    drive(6'h14, 5'h00, 32'hA, 32'hA, 32'h400, 16'h8, "R6 eq likely taken");
    drive(6'h14, 5'h00, 32'hA, 32'hB, 32'h400, 16'h8, "R6 eq likely not");
    drive(6'h15, 5'h00, 32'hA, 32'hA, 32'h400, 16'h8, "R6 ne likely not");
    drive(6'h15, 5'h00, 32'hA, 32'hB, 32'h400, 16'h8, "R6 ne likely taken");
    drive(6'h04, 5'h00, 32'h0, 32'h0, 32'h1000, 16'h7FFF, "R7 max pos offset");
    drive(6'h04, 5'h00, 32'h0, 32'h0, 32'h1000, 16'h8000, "R7 max neg offset");
    drive(6'h04, 5'h00, 32'h0, 32'h0, 32'hFFFF_FFFC, 16'h1, "R7 wrap");
    drive(6'h01, 5'h11, 32'h0, 32'h0, 32'hFFFF_FFFC, 16'h0, "R3 link wrap");
    for (int s = 0; s < 32; s++)
      drive(6'h01, 5'(s), 32'h8000_0000, 32'h0, 32'h500, 16'h2, "R9 selector sweep");
    for (int op = 0; op < 64; op++)
      drive(6'(op), 5'h10, 32'h0, 32'h0, 32'h600, 16'h3, "R8 R9 opcode sweep");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
  end

  initial begin
    int cyc;
    cyc = 0;
    while (!done && cyc < WATCHDOG) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog: got timeout exp completion");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule